// File: doc/BRIEF.md
# Random-Access Port Front End with Command Register Bank

This block sits at the front of the asynchronous random-access side of a 4096 x 16 memory that also has a second, sequential access path. On every rising clock edge it samples the port pins: chip select, command select, read/write, output enable and two byte-lane enables. From these it picks one of six access states. It then either drives the strobes, address, write data and byte-lane mask toward the external storage array, or it reaches a small bank of command registers addressed by the three low address bits. It also gates a per-lane output enable for the shared data bus. If chip select and command select are both low, the block flags the combination as illegal and blocks every write and every drive.

The access state is held in one state register. That register is loaded from a combinational decode of the sampled pins. All outputs follow the registered state during the cycle after the sampling edge. The state names are ST_OFF (power-down), ST_ARR_RD, ST_ARR_WR, ST_REG_RD, ST_REG_WR and ST_BAD. The register reached is taken from the state itself, without looking at the previous state. On each edge the next state is therefore chosen from the sampled pins alone:

| Chip select | Command select | Read/write | Next state |
|---|---|---|---|
| high | high | any | ST_OFF |
| low | high | high | ST_ARR_RD |
| low | high | low | ST_ARR_WR |
| high | low | high | ST_REG_RD |
| high | low | low | ST_REG_WR |
| low | low | any | ST_BAD |

A register write takes effect on the clock edge that ends its ST_REG_WR cycle. The register bank holds two 12-bit start pointers, two 12-bit end pointers, a 13-bit control word and two end-of-buffer flags. The flags are raised by pulses from the sequential side.

Top module: `rap_frontend`

## Requirements
- R1: Chip select low, command select high and read/write high, sampled at an edge, give ST_ARR_RD for the next cycle. In that cycle mem_en=1, mem_we=0 and mem_addr equals the sampled address. With output enable also sampled low, dq_out carries mem_rdata on the enabled lanes.
- R2: Chip select low, command select high and read/write low give ST_ARR_WR for the next cycle. In that cycle mem_en=1, mem_wdata equals the sampled data, and mem_be = {~ub_n, ~lb_n}, where bit 0 is lane bits 7:0 and bit 1 is lane bits 15:8. mem_we=1 when at least one lane is enabled.
- R3: A disabled byte lane is neither written nor driven. Its mem_be bit and its dq_oe bit are 0, and its dq_out bits are 0. With both lanes disabled, mem_we=0.
- R4: dq_oe is nonzero only in a read state whose sampled output enable was low. Any write, or output enable high, gives dq_oe=00.
- R5: Chip select and command select both high give ST_OFF. In that state mem_en=0, mem_we=0, mem_be=00 and dq_oe=00, and register contents are retained.
- R6: Chip select and command select both low give ST_BAD. In that state bad_combo=1, mem_en=0, mem_we=0 and dq_oe=00, and no register is written. bad_combo=0 in every other state.
- R7: In register mode, address bits 2:0 select the register. Codes 000, 001, 010 and 011 store data bits 11:0 as start 1, start 2, end 1 and end 2. Reads of these codes return the value zero-extended to 16 bits. Reads of 110 and 111 return 0. A register read drives both lanes when output enable is sampled low.
- R8: Code 100 reads the flag register as {14'b0, flag2, flag1}. A write to code 100 changes nothing.
- R9: Code 101 is the control register. It stores data bits 12:0, and reads return them zero-extended. A write with bit 0 = 0 clears flag 1, and a write with bit 1 = 0 clears flag 2. flag_set[i] raises flag i+1 on the next edge and wins over a clear on the same edge. eob_flag[0] and eob_flag[1] show flags 1 and 2.
- R10: While rst_n is low, the state is ST_OFF, every register and both flags are 0, and bad_combo=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Array chip select, active low |
| cmd_n | input | 1 | Command register select, active low |
| rw_n | input | 1 | High = read, low = write |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | 12 | Word address; bits 2:0 select the register in command mode |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data to the bus (0 on undriven lanes) |
| dq_oe | output | 2 | Per-lane output enable for the pad drivers |
| mem_addr | output | 12 | Array address |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write strobe |
| mem_be | output | 2 | Array byte-lane write/read mask |
| mem_wdata | output | 16 | Array write data |
| mem_rdata | input | 16 | Array read data |
| flag_set | input | 2 | Raise pulses for the end-of-buffer flags from the sequential side |
| eob_flag | output | 2 | End-of-buffer flag state |
| bad_combo | output | 1 | Illegal select combination seen at the last edge |

## Verification
The hardest case to reach is a flag clear that lands on the same edge as a new raise pulse. A write to the control register only takes effect one edge after it is sampled, so the raise pulse has to be lined up with that later edge, not with the write cycle itself. The bench first raises flag 1, then samples a control write with bit 0 clear, and then drives flag_set on the following edge. It also checks the register contents after an illegal-combination write attempt, by reading them back through the normal register read path.

// File: rtl/rap_pkg.sv
package rap_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int REG_AW = 3;
    localparam int PTR_W  = 12;
    localparam int CTRL_W = 13;
    localparam int FLAG_N = 2;
    localparam int LANE_N = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_ARR_RD = 3'd1,
        ST_ARR_WR = 3'd2,
        ST_REG_RD = 3'd3,
        ST_REG_WR = 3'd4,
        ST_BAD    = 3'd5
    } rap_state_t;
endpackage

// File: rtl/rap_decode.sv
module rap_decode
    import rap_pkg::*;
(
    input  logic       ce_n,
    input  logic       cmd_n,
    input  logic       rw_n,
    output rap_state_t nxt
);
    always_comb begin
        unique case ({ce_n, cmd_n})
            2'b00:   nxt = ST_BAD;
            2'b01:   nxt = rw_n ? ST_ARR_RD : ST_ARR_WR;
            2'b10:   nxt = rw_n ? ST_REG_RD : ST_REG_WR;
            default: nxt = ST_OFF;
        endcase
    end
endmodule

// File: rtl/rap_regbank.sv
module rap_regbank
    import rap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] sel,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [FLAG_N-1:0] flag_set,
    output logic [DATA_W-1:0] rdata,
    output logic [FLAG_N-1:0] flags
);
    localparam int PTR_N = 4;
    localparam logic [REG_AW-1:0] SEL_FLAG = 3'd4;
    localparam logic [REG_AW-1:0] SEL_CTRL = 3'd5;

    logic [PTR_W-1:0]  ptr_q [PTR_N];
    logic [CTRL_W-1:0] ctrl_q;
    logic [FLAG_N-1:0] flag_q;

    for (genvar p = 0; p < PTR_N; p++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q[p] <= '0;
            else if (wr_en && sel == REG_AW'(p))
                ptr_q[p] <= wdata[PTR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && sel == SEL_CTRL)
            ctrl_q <= wdata;
    end

    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[f] <= 1'b0;
            else if (flag_set[f])
                flag_q[f] <= 1'b1;
            else if (wr_en && sel == SEL_CTRL && !wdata[f])
                flag_q[f] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel < REG_AW'(PTR_N))
            rdata = DATA_W'(ptr_q[sel[1:0]]);
        else if (sel == SEL_FLAG)
            rdata = DATA_W'(flag_q);
        else if (sel == SEL_CTRL)
            rdata = DATA_W'(ctrl_q);
    end

    assign flags = flag_q;
endmodule

// File: rtl/rap_lane_gate.sv
module rap_lane_gate #(
    parameter int LANE_W = 8
) (
    input  logic              drive,
    input  logic [LANE_W-1:0] src,
    output logic              oe,
    output logic [LANE_W-1:0] dout
);
    assign oe   = drive;
    assign dout = drive ? src : '0;
endmodule

// File: rtl/rap_frontend.sv
module rap_frontend
    import rap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cmd_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANE_N-1:0] dq_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [LANE_N-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [FLAG_N-1:0] flag_set,
    output logic [FLAG_N-1:0] eob_flag,
    output logic              bad_combo
);
    rap_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [LANE_N-1:0] lane_q;
    logic              oe_q;

    logic              reg_we;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] rd_src;
    logic [LANE_N-1:0] drive_lane;

    rap_decode u_dec (
        .ce_n  (ce_n),
        .cmd_n (cmd_n),
        .rw_n  (rw_n),
        .nxt   (state_d)
    );

    // State register plus the pin values captured with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            addr_q  <= '0;
            din_q   <= '0;
            lane_q  <= '0;
            oe_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr;
            din_q   <= dq_in;
            lane_q  <= {~ub_n, ~lb_n};
            oe_q    <= ~oe_n;
        end
    end

    // Outputs from the registered state
    always_comb begin
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_be     = '0;
        reg_we     = 1'b0;
        drive_lane = '0;
        rd_src     = '0;
        bad_combo  = 1'b0;
        unique case (state_q)
            ST_ARR_RD: begin
                mem_en     = 1'b1;
                mem_be     = lane_q;
                drive_lane = oe_q ? lane_q : '0;
                rd_src     = mem_rdata;
            end
            ST_ARR_WR: begin
                mem_en = 1'b1;
                mem_we = |lane_q;
                mem_be = lane_q;
            end
            ST_REG_RD: begin
                drive_lane = oe_q ? '1 : '0;
                rd_src     = reg_rdata;
            end
            ST_REG_WR: reg_we = 1'b1;
            ST_BAD:    bad_combo = 1'b1;
            default:   ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = din_q;

    rap_regbank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .sel      (addr_q[REG_AW-1:0]),
        .wdata    (din_q[CTRL_W-1:0]),
        .flag_set (flag_set),
        .rdata    (reg_rdata),
        .flags    (eob_flag)
    );

    for (genvar l = 0; l < LANE_N; l++) begin : g_lane
        rap_lane_gate #(.LANE_W(8)) u_gate (
            .drive (drive_lane[l]),
            .src   (rd_src[l*8 +: 8]),
            .oe    (dq_oe[l]),
            .dout  (dq_out[l*8 +: 8])
        );
    end
endmodule

// File: rtl/rap_frontend_chk.sv
module rap_frontend_chk
    import rap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              cmd_n,
    input logic              rw_n,
    input logic              oe_n,
    input logic              lb_n,
    input logic              ub_n,
    input logic [ADDR_W-1:0] addr,
    input logic [LANE_N-1:0] dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_en,
    input logic              mem_we,
    input logic [LANE_N-1:0] mem_be,
    input logic              bad_combo
);
    AST_ARRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && cmd_n && rw_n) |=> (mem_en && !mem_we && mem_addr == $past(addr))); // R1

    AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && cmd_n && !rw_n) |=> (mem_be == ~$past({ub_n, lb_n}))); // R2

    AST_NO_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != 2'b00)); // R3

    AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || !rw_n) |=> (dq_oe == 2'b00)); // R4

    AST_POWER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && cmd_n) |=> (!mem_en && !mem_we && dq_oe == 2'b00)); // R5

    AST_BAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !cmd_n) |=> (bad_combo && !mem_en && !mem_we && dq_oe == 2'b00)); // R6

    AST_BAD_ONLY_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || cmd_n) |=> !bad_combo); // R6
endmodule

bind rap_frontend rap_frontend_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .cmd_n     (cmd_n),
    .rw_n      (rw_n),
    .oe_n      (oe_n),
    .lb_n      (lb_n),
    .ub_n      (ub_n),
    .addr      (addr),
    .dq_oe     (dq_oe),
    .mem_addr  (mem_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .bad_combo (bad_combo)
);

// File: tb/sim_rap_frontend.sv
`timescale 1ns/100ps
module sim_rap_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, cmd_n = 1'b1, rw_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [11:0] mem_addr;
    logic        mem_en, mem_we;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [1:0]  flag_set = '0;
    logic [1:0]  eob_flag;
    logic        bad_combo;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Array model: read data is a fixed function of the address
    assign mem_rdata = {4'hA, mem_addr};

    rap_frontend u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_n(cmd_n), .rw_n(rw_n),
        .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .mem_addr(mem_addr), .mem_en(mem_en),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .flag_set(flag_set), .eob_flag(eob_flag),
        .bad_combo(bad_combo)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [5:0] pins, input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        {ce_n, cmd_n, rw_n, oe_n, lb_n, ub_n} = pins;
        addr = a;
        dq_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_set(input logic [1:0] fs);
        @(negedge clk);
        {ce_n, cmd_n, rw_n, oe_n, lb_n, ub_n} = 6'b111111;
        flag_set = fs;
        @(posedge clk);
        #1;
        flag_set = 2'b00;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        op(6'b100111, {9'd0, a}, d);
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] v);
        op(6'b101011, {9'd0, a}, 16'h0);
        v = dq_out;
    endtask

    // {ce,cmd,rw,oe,lb,ub} addr din | en we be oe bad
    localparam int NV = 12;
    localparam logic [40:0] TBL [NV] = '{
        {6'b010100, 12'h123, 16'hBEEF, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0}, // R2 both lanes
        {6'b010101, 12'h124, 16'h1111, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0}, // R3 lower only
        {6'b010110, 12'h125, 16'h2222, 1'b1, 1'b1, 2'b10, 2'b00, 1'b0}, // R3 upper only
        {6'b010111, 12'h126, 16'h3333, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0}, // R3 no lanes
        {6'b011000, 12'h321, 16'h0000, 1'b1, 1'b0, 2'b11, 2'b11, 1'b0}, // R1 read both
        {6'b011010, 12'h0F0, 16'h0000, 1'b1, 1'b0, 2'b10, 2'b10, 1'b0}, // R3 read upper
        {6'b011100, 12'h055, 16'h0000, 1'b1, 1'b0, 2'b11, 2'b00, 1'b0}, // R4 oe high
        {6'b010000, 12'h077, 16'h4444, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0}, // R4 write oe low
        {6'b111000, 12'h088, 16'h0000, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0}, // R5 power-down
        {6'b000100, 12'h099, 16'h5555, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1}, // R6 illegal write
        {6'b001000, 12'h0AA, 16'h0000, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1}, // R6 illegal read
        {6'b101011, 12'h000, 16'h0000, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0}  // R7 reg read drives both
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] mask;
        #12;
        // R10 reset state
        check("R10 mem_en", mem_en, 0);
        check("R10 dq_oe", dq_oe, 0);
        check("R10 bad_combo", bad_combo, 0);
        check("R10 eob_flag", eob_flag, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            op(TBL[i][40:35], TBL[i][34:23], TBL[i][22:7]);
            check($sformatf("R1-vec%0d mem_en", i), mem_en, TBL[i][6]);
            check($sformatf("R2-vec%0d mem_we", i), mem_we, TBL[i][5]);
            check($sformatf("R3-vec%0d mem_be", i), mem_be, TBL[i][4:3]);
            check($sformatf("R4-vec%0d dq_oe", i), dq_oe, TBL[i][2:1]);
            check($sformatf("R6-vec%0d bad", i), bad_combo, TBL[i][0]);
            if (TBL[i][6])
                check($sformatf("R1 vec%0d mem_addr", i), mem_addr, TBL[i][34:23]);
            if (TBL[i][5])
                check($sformatf("R2 vec%0d mem_wdata", i), mem_wdata, TBL[i][22:7]);
            if (TBL[i][6] && TBL[i][2:1] != 2'b00) begin
                mask = {{8{TBL[i][2]}}, {8{TBL[i][1]}}};
                check($sformatf("R3 vec%0d dq_out", i), dq_out, {4'hA, TBL[i][34:23]} & mask);
            end
        end

        // R7 pointer registers, 12 bits kept, zero-extended
        reg_write(3'd0, 16'hF123);
        reg_write(3'd1, 16'hA456);
        reg_write(3'd2, 16'h0789);
        reg_write(3'd3, 16'hFABC);
        reg_read(3'd0, v); check("R7 start1", v, 16'h0123);
        reg_read(3'd1, v); check("R7 start2", v, 16'h0456);
        reg_read(3'd2, v); check("R7 end1", v, 16'h0789);
        reg_read(3'd3, v); check("R7 end2", v, 16'h0ABC);
        reg_read(3'd6, v); check("R7 code110", v, 16'h0000);
        reg_read(3'd7, v); check("R7 code111", v, 16'h0000);

        // R9 control register keeps 13 bits
        reg_write(3'd5, 16'hFFFF);
        reg_read(3'd5, v); check("R9 ctrl readback", v, 16'h1FFF);

        // R9 raise, R8 read-only flag register
        idle_set(2'b11);
        check("R9 flags raised", eob_flag, 2'b11);
        reg_read(3'd4, v); check("R8 flag read", v, 16'h0003);
        reg_write(3'd4, 16'h0000);
        idle_set(2'b00);
        check("R8 flag write ignored", eob_flag, 2'b11);
        reg_read(3'd4, v); check("R8 flag read after write", v, 16'h0003);

        // R9 clears
        reg_write(3'd5, 16'h1FFE);
        idle_set(2'b00);
        check("R9 clear flag1", eob_flag, 2'b10);
        reg_write(3'd5, 16'h0001);
        idle_set(2'b00);
        check("R9 clear flag2", eob_flag, 2'b00);

        // R9 raise wins over clear on the same edge
        idle_set(2'b01);
        reg_write(3'd5, 16'h1FFE);
        idle_set(2'b01);
        idle_set(2'b00);
        check("R9 raise beats clear", eob_flag, 2'b01);

        // R6 illegal combination does not write a register
        op(6'b000111, 12'h000, 16'h0FFF);
        check("R6 bad flag", bad_combo, 1);
        reg_read(3'd0, v); check("R6 start1 untouched", v, 16'h0123);

        // R5 retention across power-down
        for (int k = 0; k < 4; k++) idle_set(2'b00);
        check("R5 off dq_oe", dq_oe, 0);
        reg_read(3'd1, v); check("R5 start2 retained", v, 16'h0456);

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 flags cleared", eob_flag, 2'b00);
        check("R10 no drive", dq_oe, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        reg_read(3'd0, v); check("R10 start1 cleared", v, 16'h0000);
        reg_read(3'd5, v); check("R10 ctrl cleared", v, 16'h0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule